// File: doc/BRIEF.md
# I2C Slave Address Match and Bus Monitor Unit

This unit sits behind the bit-level receiver of an I2C target port. It is fed one strobe for each START or repeated START, one strobe for each sampled SDA bit, and a level that marks the ninth-bit (acknowledge) period. From that stream it works out whether the first byte after each START names this device. Four address entries are held on configuration inputs. Each entry has its own don't-care mask and its own general-call enable. The unit reports which entry matched, the direction bit and whether the general-call address was seen. It then drives the acknowledge on SDA and holds SCL low while an interrupt is pending.

A passive monitor mode turns the port into a listener. SDA is never driven. SCL is released unless a separate clock-enable bit allows stretching. With the match-all option, every address on the bus raises the interrupt. Independent of any match, every complete 9-bit frame leaves its eight data bits in a capture buffer, so software can follow all traffic.

Top module: `i2c_addr_watch`

## Requirements
- R1: After synchronous reset, addr_hit, hit_idx, gen_call, rw_bit, irq, snoop_byte and snoop_vld are 0, and sda_oe and scl_oe are 0 (both lines released).
- R2: Bits arrive MSB first. The first byte after a START is evaluated on the cycle its eighth data strobe is sampled, and the result registers appear one clock later. Byte bits 7:1 are compared with bits 7:1 of each entry, and byte bit 0 is reported on rw_bit without being compared. Each entry is 8 bits wide inside ent_addr, with entry k at bits 8k+7:8k.
- R3: A 1 in bit j (j in 7:1) of an entry's mask makes address bit j a don't-care for that entry. A 0 requires equality. Mask bit 0 has no effect. Entry k's mask sits at ent_mask bits 8k+7:8k.
- R4: An all-zero address matches exactly those entries whose bit 0 (general-call enable) is 1, whatever their masks say, and it sets gen_call along with addr_hit.
- R5: When several entries match, hit_idx gives the lowest-numbered one. With no match, addr_hit and hit_idx are 0.
- R6: While rx_ack_slot is high after a matched address byte, sda_oe is 1 up to and including the ninth-bit strobe of that byte. It is always 0 while mon_en is 1.
- R7: scl_oe equals irq when mon_en is 0. In monitor mode it equals irq when mon_scl_en is 1, and it is 0 when mon_scl_en is 0.
- R8: irq is set by an address evaluation that matched, or by any address evaluation when both mon_en and mon_match_all are 1. mon_match_all alone has no effect. irq stays set until irq_clr. If a set and irq_clr fall in the same cycle, the set wins.
- R9: On every ninth-bit strobe (rx_bit_vld with rx_ack_slot), the eight data bits received since the previous frame boundary are loaded into snoop_byte, with zeros above a short frame, and snoop_vld pulses for one cycle. This happens for every frame, matched or not.
- R10: Only the first byte after a START is compared. Later bytes leave addr_hit, hit_idx, gen_call and rw_bit unchanged. A START clears those four outputs and the pending acknowledge, and it takes priority over a bit strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start | input | 1 | START or repeated START seen |
| rx_bit_vld | input | 1 | One sampled SDA bit is valid |
| rx_bit | input | 1 | Sampled SDA value |
| rx_ack_slot | input | 1 | High during the ninth (acknowledge) bit period |
| ent_addr | input | 8*NUM_ENT | Entry addresses (7:1) and general-call enables (0) |
| ent_mask | input | 8*NUM_ENT | Entry don't-care masks (7:1); bit 0 unused |
| mon_en | input | 1 | Monitor mode |
| mon_scl_en | input | 1 | Allow clock stretching in monitor mode |
| mon_match_all | input | 1 | Interrupt on every address in monitor mode |
| irq_clr | input | 1 | Clears the interrupt flag |
| addr_hit | output | 1 | Last address matched an entry |
| hit_idx | output | IDX_W | Lowest matching entry |
| gen_call | output | 1 | Matched through the general-call address |
| rw_bit | output | 1 | Direction bit of the last address |
| irq | output | 1 | Sticky interrupt flag |
| sda_oe | output | 1 | Pull SDA low (acknowledge) |
| scl_oe | output | 1 | Hold SCL low (stretch) |
| snoop_byte | output | 8 | Data bits of the last complete frame |
| snoop_vld | output | 1 | One-cycle pulse when snoop_byte is loaded |

## Verification
On every cycle, the assertions check that monitor mode never lets SDA be driven and releases SCL unless stretching is allowed. They also check that the interrupt stays set without a clear, that a general-call report always comes with a hit, that a START wipes the match result, and that a capture pulse follows only a ninth-bit strobe. The cases that need the bench's scenarios and its reference model are these: the masked and exact comparisons, the general call bypassing the masks, lowest-index priority, set-over-clear on the interrupt, short frames in the capture buffer, and the bytes after the first one leaving the match untouched.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    // One address entry: bits 7:1 address, bit 0 general-call enable
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              gc_en;
    } ent_t;

    // Result of one entry comparison
    typedef struct packed {
        logic hit;
        logic via_gc;
    } cmp_res_t;

    // Address as seen on the bus (first byte after START)
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rw;
    } addr_byte_t;

    function automatic cmp_res_t entry_compare(
        input logic [ADDR_W-1:0] rx_addr,
        input ent_t              ent,
        input logic [ADDR_W-1:0] dont_care
    );
        cmp_res_t r;
        if (rx_addr == '0) begin
            r.hit    = ent.gc_en;
            r.via_gc = ent.gc_en;
        end else begin
            r.hit    = (((rx_addr ^ ent.addr) & ~dont_care) == '0);
            r.via_gc = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/i2cam_frame_rx.sv
module i2cam_frame_rx
    import i2cam_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_start,
    input  logic              rx_bit_vld,
    input  logic              rx_bit,
    input  logic              rx_ack_slot,
    output logic              addr_eval,
    output addr_byte_t        addr_byte,
    output logic              frame_end,
    output logic [BYTE_W-1:0] snoop_byte,
    output logic              snoop_vld
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              first_byte;
    logic              data_bit;

    assign data_bit  = rx_bit_vld && !rx_ack_slot && !rx_start;
    assign frame_end = rx_bit_vld && rx_ack_slot && !rx_start;
    assign addr_eval = data_bit && first_byte && (bit_cnt == CNT_LAST);
    assign addr_byte = addr_byte_t'({shreg[BYTE_W-2:0], rx_bit});

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg      <= '0;
            bit_cnt    <= '0;
            first_byte <= 1'b0;
            snoop_byte <= '0;
            snoop_vld  <= 1'b0;
        end else begin
            snoop_vld <= 1'b0;
            if (rx_start) begin
                shreg      <= '0;
                bit_cnt    <= '0;
                first_byte <= 1'b1;
            end else if (frame_end) begin
                snoop_byte <= shreg;
                snoop_vld  <= 1'b1;
                shreg      <= '0;
                bit_cnt    <= '0;
                first_byte <= 1'b0;
            end else if (data_bit) begin
                shreg <= {shreg[BYTE_W-2:0], rx_bit};
                if (bit_cnt != CNT_FULL) begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/i2cam_entry_cmp.sv
module i2cam_entry_cmp
    import i2cam_pkg::*;
#(
    parameter int NUM_ENT = 4
) (
    input  logic [ADDR_W-1:0]         rx_addr,
    input  logic [NUM_ENT*BYTE_W-1:0] ent_addr,
    input  logic [NUM_ENT*BYTE_W-1:0] ent_mask,
    output logic [NUM_ENT-1:0]        hit_vec,
    output logic                      gc_seen
);

    logic [NUM_ENT-1:0] gc_vec;

    for (genvar k = 0; k < NUM_ENT; k++) begin : g_ent
        ent_t              ent;
        logic [ADDR_W-1:0] dc;
        cmp_res_t          res;
        assign ent        = ent_t'(ent_addr[k*BYTE_W +: BYTE_W]);
        assign dc         = ent_mask[k*BYTE_W+1 +: ADDR_W];
        assign res        = entry_compare(rx_addr, ent, dc);
        assign hit_vec[k] = res.hit;
        assign gc_vec[k]  = res.via_gc;
    end

    assign gc_seen = |gc_vec;

endmodule

// File: rtl/i2cam_prio_pick.sv
module i2cam_prio_pick #(
    parameter int NUM_ENT = 4,
    localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic [NUM_ENT-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        idx = '0;
        for (int k = NUM_ENT - 1; k >= 0; k--) begin
            if (req[k]) begin
                idx = IDX_W'(k);
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/i2c_addr_watch.sv
module i2c_addr_watch
    import i2cam_pkg::*;
#(
    parameter int NUM_ENT = 4,
    localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rx_start,
    input  logic                      rx_bit_vld,
    input  logic                      rx_bit,
    input  logic                      rx_ack_slot,
    input  logic [NUM_ENT*BYTE_W-1:0] ent_addr,
    input  logic [NUM_ENT*BYTE_W-1:0] ent_mask,
    input  logic                      mon_en,
    input  logic                      mon_scl_en,
    input  logic                      mon_match_all,
    input  logic                      irq_clr,
    output logic                      addr_hit,
    output logic [IDX_W-1:0]          hit_idx,
    output logic                      gen_call,
    output logic                      rw_bit,
    output logic                      irq,
    output logic                      sda_oe,
    output logic                      scl_oe,
    output logic [BYTE_W-1:0]         snoop_byte,
    output logic                      snoop_vld
);

    logic               addr_eval;
    logic               frame_end;
    addr_byte_t         abyte;
    logic [NUM_ENT-1:0] hit_vec;
    logic               gc_seen;
    logic               any_hit;
    logic [IDX_W-1:0]   pick_idx;
    logic               ack_pend;
    logic               irq_set;

    i2cam_frame_rx u_frame (
        .clk        (clk),
        .rst        (rst),
        .rx_start   (rx_start),
        .rx_bit_vld (rx_bit_vld),
        .rx_bit     (rx_bit),
        .rx_ack_slot(rx_ack_slot),
        .addr_eval  (addr_eval),
        .addr_byte  (abyte),
        .frame_end  (frame_end),
        .snoop_byte (snoop_byte),
        .snoop_vld  (snoop_vld)
    );

    i2cam_entry_cmp #(.NUM_ENT(NUM_ENT)) u_cmp (
        .rx_addr (abyte.addr),
        .ent_addr(ent_addr),
        .ent_mask(ent_mask),
        .hit_vec (hit_vec),
        .gc_seen (gc_seen)
    );

    i2cam_prio_pick #(.NUM_ENT(NUM_ENT)) u_pick (
        .req(hit_vec),
        .any(any_hit),
        .idx(pick_idx)
    );

    assign irq_set = addr_eval && (any_hit || (mon_en && mon_match_all));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_hit <= 1'b0;
            hit_idx  <= '0;
            gen_call <= 1'b0;
            rw_bit   <= 1'b0;
            ack_pend <= 1'b0;
        end else if (rx_start) begin
            addr_hit <= 1'b0;
            hit_idx  <= '0;
            gen_call <= 1'b0;
            rw_bit   <= 1'b0;
            ack_pend <= 1'b0;
        end else if (addr_eval) begin
            addr_hit <= any_hit;
            hit_idx  <= pick_idx;
            gen_call <= gc_seen;
            rw_bit   <= abyte.rw;
            ack_pend <= any_hit;
        end else if (frame_end) begin
            ack_pend <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (irq_set) begin
            irq <= 1'b1;
        end else if (irq_clr) begin
            irq <= 1'b0;
        end
    end

    assign sda_oe = ack_pend && rx_ack_slot && !mon_en;
    assign scl_oe = irq && (!mon_en || mon_scl_en);

endmodule

// File: rtl/i2c_addr_watch_chk.sv
module i2c_addr_watch_chk (
    input logic clk,
    input logic rst,
    input logic rx_start,
    input logic rx_bit_vld,
    input logic rx_ack_slot,
    input logic mon_en,
    input logic mon_scl_en,
    input logic irq_clr,
    input logic addr_hit,
    input logic gen_call,
    input logic irq,
    input logic sda_oe,
    input logic scl_oe,
    input logic snoop_vld
);

    assert_sda_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        mon_en |-> !sda_oe);

    assert_scl_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (mon_en && !mon_scl_en) |-> !scl_oe);

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    assert_gc_implies_hit_R4: assert property (@(posedge clk) disable iff (rst)
        gen_call |-> addr_hit);

    assert_start_clears_R10: assert property (@(posedge clk) disable iff (rst)
        rx_start |=> (!addr_hit && !gen_call));

    assert_snoop_source_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(snoop_vld) |-> $past(rx_bit_vld && rx_ack_slot && !rx_start));

endmodule

bind i2c_addr_watch i2c_addr_watch_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_start   (rx_start),
    .rx_bit_vld (rx_bit_vld),
    .rx_ack_slot(rx_ack_slot),
    .mon_en     (mon_en),
    .mon_scl_en (mon_scl_en),
    .irq_clr    (irq_clr),
    .addr_hit   (addr_hit),
    .gen_call   (gen_call),
    .irq        (irq),
    .sda_oe     (sda_oe),
    .scl_oe     (scl_oe),
    .snoop_vld  (snoop_vld)
);

// File: tb/test_i2c_addr_watch.sv
module test_i2c_addr_watch;

    localparam int NE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_start = 1'b0;
    logic        rx_bit_vld = 1'b0;
    logic        rx_bit = 1'b0;
    logic        rx_ack_slot = 1'b0;
    logic [31:0] ent_addr = '0;
    logic [31:0] ent_mask = '0;
    logic        mon_en = 1'b0;
    logic        mon_scl_en = 1'b0;
    logic        mon_match_all = 1'b0;
    logic        irq_clr = 1'b0;
    logic        addr_hit, gen_call, rw_bit, irq, sda_oe, scl_oe, snoop_vld;
    logic [1:0]  hit_idx;
    logic [7:0]  snoop_byte;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit armed   = 0;

    always #10 clk = ~clk;

    i2c_addr_watch #(.NUM_ENT(NE)) i_i2c_addr_watch (
        .clk(clk), .rst(rst), .rx_start(rx_start), .rx_bit_vld(rx_bit_vld),
        .rx_bit(rx_bit), .rx_ack_slot(rx_ack_slot), .ent_addr(ent_addr),
        .ent_mask(ent_mask), .mon_en(mon_en), .mon_scl_en(mon_scl_en),
        .mon_match_all(mon_match_all), .irq_clr(irq_clr), .addr_hit(addr_hit),
        .hit_idx(hit_idx), .gen_call(gen_call), .rw_bit(rw_bit), .irq(irq),
        .sda_oe(sda_oe), .scl_oe(scl_oe), .snoop_byte(snoop_byte),
        .snoop_vld(snoop_vld)
    );

    // Behavioural reference model
    bit mq[$];
    int m_first, m_hit, m_idx, m_gc, m_rw, m_irq, m_snoop, m_svld, m_ackp;

    always @(posedge clk) begin
        int val, addr, any, first_idx, set_irq;
        armed = 1;
        set_irq = 0;
        if (rst) begin
            mq.delete();
            m_first = 0; m_hit = 0; m_idx = 0; m_gc = 0; m_rw = 0;
            m_irq = 0; m_snoop = 0; m_svld = 0; m_ackp = 0;
        end else begin
            m_svld = 0;
            if (rx_start) begin
                mq.delete();
                m_first = 1; m_hit = 0; m_idx = 0; m_gc = 0; m_rw = 0; m_ackp = 0;
            end else if (rx_bit_vld && rx_ack_slot) begin
                val = 0;
                foreach (mq[i]) val = ((val << 1) | mq[i]) & 255;
                m_snoop = val; m_svld = 1; m_first = 0; m_ackp = 0;
                mq.delete();
            end else if (rx_bit_vld) begin
                mq.push_back(rx_bit);
                if (m_first == 1 && mq.size() == 8) begin
                    val = 0;
                    foreach (mq[i]) val = (val << 1) | mq[i];
                    addr = val / 2;
                    any = 0; first_idx = 0;
                    for (int e = NE - 1; e >= 0; e--) begin
                        int ea, em, ok;
                        ea = (ent_addr >> (8 * e)) & 255;
                        em = (ent_mask >> (8 * e)) & 255;
                        if (addr == 0) ok = ea % 2;
                        else ok = (((addr ^ (ea / 2)) & ~(em / 2) & 127) == 0);
                        if (ok != 0) begin any = 1; first_idx = e; end
                    end
                    m_hit = any; m_idx = first_idx; m_gc = (addr == 0) && any;
                    m_rw = val % 2; m_ackp = any;
                    set_irq = any || (mon_en && mon_match_all);
                end
            end
            if (set_irq != 0) m_irq = 1;
            else if (irq_clr) m_irq = 0;
        end
    end

    task automatic cmp(input string tag, input string nm, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h at cycle %0d", tag, nm, got, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (armed) begin
            cmp("R2", "addr_hit", int'(addr_hit), m_hit);
            cmp("R5", "hit_idx", int'(hit_idx), m_idx);
            cmp("R4", "gen_call", int'(gen_call), m_gc);
            cmp("R2", "rw_bit", int'(rw_bit), m_rw);
            cmp("R8", "irq", int'(irq), m_irq);
            cmp("R9", "snoop_byte", int'(snoop_byte), m_snoop);
            cmp("R9", "snoop_vld", int'(snoop_vld), m_svld);
            cmp("R6", "sda_oe", int'(sda_oe), int'(m_ackp != 0 && rx_ack_slot && !mon_en));
            cmp("R7", "scl_oe", int'(scl_oe), int'(m_irq != 0 && (!mon_en || mon_scl_en)));
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        rx_start = 0; rx_bit_vld = 0; rx_ack_slot = 0; irq_clr = 0;
        tick();
    endtask

    task automatic send_start();
        rx_start = 1; tick(); idle();
    endtask

    task automatic send_frame(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            rx_bit_vld = 1; rx_bit = b[i]; tick(); idle();
        end
        rx_ack_slot = 1; rx_bit = 1'b0; tick();      // acknowledge window
        rx_bit_vld = 1; tick();                      // ninth-bit strobe
        idle(); idle();
    endtask

    task automatic direct(input string tag, input string nm, input int got, input int exp);
        @(negedge clk);
        cmp(tag, nm, got, exp);
        #2;
    endtask

    initial begin
        ent_addr = {8'hD6, 8'hC0, 8'h75, 8'hA0};
        ent_mask = {8'h00, 8'h1F, 8'h00, 8'h00};
        repeat (3) tick();
        rst = 0; idle();
        // R1: reset values
        @(negedge clk);
        cmp("R1", "reset_outs", int'({addr_hit, hit_idx, gen_call, rw_bit, irq, sda_oe, scl_oe, snoop_vld}), 0);
        cmp("R1", "reset_snoop", int'(snoop_byte), 0);
        #2;

        // R2: exact match on entry 0, write
        send_start(); send_frame({7'h50, 1'b0}, 8);
        direct("R2", "hit_e0", int'({addr_hit, hit_idx}), 4);
        // R10: data byte leaves match intact, R9 captures it
        send_frame(8'h3C, 8);
        direct("R10", "hit_kept", int'(addr_hit), 1);
        direct("R9", "snoop_data", int'(snoop_byte), 8'h3C);
        irq_clr = 1; tick(); idle();

        // R3 + R5: 0x6B matches masked entry 2 and exact entry 3; lowest wins
        send_start(); send_frame({7'h6B, 1'b1}, 8);
        direct("R3", "masked_hit", int'({addr_hit, hit_idx, rw_bit}), 4'b1101);
        // R3: 0x70 outside the mask window
        send_start(); send_frame({7'h70, 1'b0}, 8);
        direct("R3", "mask_miss", int'(addr_hit), 0);
        irq_clr = 1; tick(); idle();

        // R4: general call with entry 0 fully masked but gc disabled
        ent_mask[7:0] = 8'hFF;
        send_start(); send_frame(8'h00, 8);
        direct("R4", "gc_idx", int'({gen_call, hit_idx}), 3'b101);
        send_start(); send_frame({7'h11, 1'b0}, 8);
        direct("R3", "full_mask_hit", int'({addr_hit, hit_idx}), 4);
        ent_mask[7:0] = 8'h00;
        irq_clr = 1; tick(); idle();

        // no match, then match-all without monitor has no effect (R8)
        send_start(); send_frame({7'h11, 1'b0}, 8);
        mon_match_all = 1;
        send_start(); send_frame({7'h12, 1'b0}, 8);
        direct("R8", "matchall_no_mon", int'(irq), 0);

        // R8/R7: monitor + match-all, no stretching
        mon_en = 1;
        send_start(); send_frame({7'h12, 1'b0}, 8);
        direct("R7", "mon_scl_off", int'({irq, scl_oe}), 2'b10);
        mon_scl_en = 1; idle();
        direct("R7", "mon_scl_on", int'(scl_oe), 1);
        // R6: matched address in monitor never drives SDA
        send_start(); send_frame({7'h50, 1'b0}, 8);
        mon_en = 0; mon_scl_en = 0; mon_match_all = 0;
        idle();

        // R8: set and clear in the same cycle -> set wins
        irq_clr = 1; tick(); idle();
        send_start();
        for (int i = 7; i >= 0; i--) begin
            rx_bit_vld = 1; rx_bit = (i == 7 || i == 5) ? 1'b1 : 1'b0;  // 0xA0
            if (i == 0) irq_clr = 1;
            tick(); idle();
        end
        direct("R8", "set_over_clr", int'(irq), 1);
        rx_ack_slot = 1; tick(); rx_bit_vld = 1; tick(); idle();

        // R9/R10: START mid-byte, then a short frame
        send_start();
        rx_bit_vld = 1; rx_bit = 1; tick(); idle();
        rx_start = 1; rx_bit_vld = 1; tick(); idle();
        send_frame(8'hE0, 3);
        direct("R9", "short_frame", int'(snoop_byte), 7);
        direct("R10", "short_no_eval", int'(addr_hit), 0);

        repeat (4) idle();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule